// File: doc/BRIEF.md
# ISA I/O Window Address Translator

This block sits between a 32-bit processor bus and an ISA-style I/O port bus. It claims processor accesses that fall inside an 8 MB window at 0x80000000 and turns each into one access on the port bus. The port address comes from one of two maps, selected per access by a map-select input. In the dense map the low 16 address bits are used as they are. In the sparse map each 4 KB page of the window becomes one 32-byte group of ports.

The processor may run big-endian. In that case 16-bit and 32-bit data are byte-swapped on the way out (write data) and on the way back (read data). Byte accesses are never swapped. Accesses outside the window never reach the port bus, and reads outside the window return zero.

Only one access may be in flight at a time. A read remains pending until the port bus answers. The size and endian setting are captured when the access is issued, so the answer is swapped according to the settings at issue time.

Top module: `iowin_xlate`

## Requirements
- R1: An access whose address has bits [31:23] equal to 9'h100 (0x80000000 to 0x807FFFFF) gives a one-cycle `port_wr` or `port_rd` pulse in the cycle after the request. Any other address gives no port strobe.
- R2: With `map_sparse`=0, `port_addr` equals request address bits [15:0].
- R3: With `map_sparse`=1, `port_addr` is {address bits [22:12], address bits [4:0]}. Address bits [11:5] have no effect.
- R4: Data passes unchanged in both directions for byte accesses (`cpu_size`=0) and whenever `big_endian`=0.
- R5: A half-word access (`cpu_size`=1) with `big_endian`=1 swaps bits [7:0] with bits [15:8] in both directions. Bits [31:16] pass unchanged.
- R6: A word access (`cpu_size`=2, or the spare code 3) with `big_endian`=1 reverses all four bytes in both directions.
- R7: A read outside the window gives no port strobe. It returns `cpu_rvalid`=1 with `cpu_rdata`=0 in the cycle after the request.
- R8: After a read inside the window, `cpu_rvalid` pulses exactly once, in the cycle after the first `port_rvalid`. It stays low while the read waits for that answer.
- R9: Size, endian mode and map mode are taken at the request. Changing `big_endian` or `map_sparse` while a read is pending does not change the returned data.
- R10: `port_rvalid` with no read pending is ignored: `cpu_rvalid` stays low.
- R11: `cpu_rd` and `cpu_wr` high together act as a write alone. `port_size` repeats the request's size code.
- R12: After reset, `port_rd`, `port_wr` and `cpu_rvalid` are low and `port_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 32 | Processor bus address |
| cpu_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word, 3 treated as word |
| cpu_rd | input | 1 | Read request, one cycle |
| cpu_wr | input | 1 | Write request, one cycle |
| cpu_wdata | input | 32 | Write data from the processor |
| map_sparse | input | 1 | 0 dense map, 1 sparse page-folded map |
| big_endian | input | 1 | Processor runs big-endian |
| port_rdata | input | 32 | Read data from the port bus |
| port_rvalid | input | 1 | Port bus read answer valid |
| port_addr | output | 16 | Translated port address |
| port_rd | output | 1 | Port read strobe |
| port_wr | output | 1 | Port write strobe |
| port_size | output | 2 | Size code of the port access |
| port_wdata | output | 32 | Lane-swapped write data |
| cpu_rdata | output | 32 | Lane-swapped read data to the processor |
| cpu_rvalid | output | 1 | Read data valid to the processor |

## Verification
The bench builds the block with the default parameters: a window base of 0x80000000, 23 window bits, a 16-bit port address, 4 KB pages and 32-byte groups. With these values a small set of chosen addresses reaches both ends of the window and both extremes of the sparse fold. Address 0x807FF01F folds to port 0xFFFF. Addresses 0x807FFFFF and 0x80800000 test the top edge of the window. Reads held pending for several cycles expose any late sampling of the endian and map inputs.

// File: rtl/iowin_pkg.sv
`timescale 1ns/1ps
package iowin_pkg;

  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    SW_NONE = 2'd0,
    SW_HALF = 2'd1,
    SW_FULL = 2'd2
  } swap_kind_e;

  // Which lane reordering an access needs.
  function automatic swap_kind_e swap_kind(input acc_size_e sz, input logic be);
    swap_kind_e k;
    if (!be) k = SW_NONE;
    else begin
      case (sz)
        SZ_BYTE: k = SW_NONE;
        SZ_HALF: k = SW_HALF;
        default: k = SW_FULL;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/iowin_addr_map.sv
`timescale 1ns/1ps
module iowin_addr_map #(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
  parameter int          WIN_BITS   = 23,
  parameter int          PORT_AW    = 16,
  parameter int          PAGE_SHIFT = 12,
  parameter int          GROUP_BITS = 5
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               sparse,
  output logic               hit,
  output logic [PORT_AW-1:0] port_addr
);
  localparam int SPAN_BITS = PORT_AW - GROUP_BITS;
  localparam int TAG_W     = ADDR_W - WIN_BITS;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_BITS];

  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:WIN_BITS] == WIN_TAG;
  endfunction

  function automatic logic [PORT_AW-1:0] dense_map(input logic [ADDR_W-1:0] a);
    return a[PORT_AW-1:0];
  endfunction

  // One page of the window becomes one group of ports.
  function automatic logic [PORT_AW-1:0] sparse_map(input logic [ADDR_W-1:0] a);
    return {a[PAGE_SHIFT +: SPAN_BITS], a[GROUP_BITS-1:0]};
  endfunction

  logic [PORT_AW-1:0] dense_addr;
  logic [PORT_AW-1:0] sparse_addr;

  always_comb begin
    hit         = in_window(addr);
    dense_addr  = dense_map(addr);
    sparse_addr = sparse_map(addr);
    port_addr   = sparse ? sparse_addr : dense_addr;
  end
endmodule

// File: rtl/iowin_lane_swap.sv
`timescale 1ns/1ps
module iowin_lane_swap
  import iowin_pkg::*;
#(
  parameter int NLANES = LANES
) (
  input  logic [8*NLANES-1:0] din,
  input  logic [1:0]          size,
  input  logic                be,
  output logic [8*NLANES-1:0] dout
);
  logic [8*NLANES-1:0] rev_all;
  logic [8*NLANES-1:0] rev_low;
  swap_kind_e          kind;

  for (genvar i = 0; i < NLANES; i++) begin : g_rev
    assign rev_all[8*i +: 8] = din[8*(NLANES-1-i) +: 8];
  end

  for (genvar i = 0; i < NLANES; i++) begin : g_half
    if (i < 2) begin : g_lo
      assign rev_low[8*i +: 8] = din[8*(1-i) +: 8];
    end else begin : g_hi
      assign rev_low[8*i +: 8] = din[8*i +: 8];
    end
  end

  always_comb begin
    kind = swap_kind(acc_size_e'(size), be);
    case (kind)
      SW_HALF: dout = rev_low;
      SW_FULL: dout = rev_all;
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/iowin_read_ret.sv
`timescale 1ns/1ps
module iowin_read_ret
  import iowin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_hit,
  input  logic              start_miss,
  input  logic [1:0]        req_size,
  input  logic              req_be,
  input  logic              port_rvalid,
  input  logic [DATA_W-1:0] port_rdata,
  output logic              pend,
  output logic              ret_fire,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata
);
  logic [1:0]        cap_size;
  logic              cap_be;
  logic [DATA_W-1:0] swapped;

  iowin_lane_swap #(.NLANES(LANES)) u_rswap (
    .din  (port_rdata),
    .size (cap_size),
    .be   (cap_be),
    .dout (swapped)
  );

  assign ret_fire = pend && port_rvalid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      cap_size   <= 2'd0;
      cap_be     <= 1'b0;
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
    end else begin
      if (ret_fire) begin
        pend       <= 1'b0;
        cpu_rvalid <= 1'b1;
        cpu_rdata  <= swapped;
      end else if (start_miss && !pend) begin
        cpu_rvalid <= 1'b1;
        cpu_rdata  <= '0;
      end else begin
        cpu_rvalid <= 1'b0;
      end
      if (start_hit && !pend) begin
        pend     <= 1'b1;
        cap_size <= req_size;
        cap_be   <= req_be;
      end
    end
  end
endmodule

// File: rtl/iowin_xlate.sv
`timescale 1ns/1ps
module iowin_xlate
  import iowin_pkg::*;
#(
  parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
  parameter int          WIN_BITS   = 23,
  parameter int          PORT_AW    = 16,
  parameter int          PAGE_SHIFT = 12,
  parameter int          GROUP_BITS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        cpu_addr,
  input  logic [1:0]         cpu_size,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [31:0]        cpu_wdata,
  input  logic               map_sparse,
  input  logic               big_endian,
  input  logic [31:0]        port_rdata,
  input  logic               port_rvalid,
  output logic [PORT_AW-1:0] port_addr,
  output logic               port_rd,
  output logic               port_wr,
  output logic [1:0]         port_size,
  output logic [31:0]        port_wdata,
  output logic [31:0]        cpu_rdata,
  output logic               cpu_rvalid
);
  // Named internal events, used by the bound checker.
  logic               acc_hit;
  logic               acc_wr;
  logic               acc_rd;
  logic               rd_pend;
  logic               ret_fire;
  logic [PORT_AW-1:0] mapped_addr;
  logic [31:0]        wdata_sw;

  assign acc_wr = cpu_wr;
  assign acc_rd = cpu_rd && !cpu_wr;

  iowin_addr_map #(
    .ADDR_W     (32),
    .WIN_BASE   (WIN_BASE),
    .WIN_BITS   (WIN_BITS),
    .PORT_AW    (PORT_AW),
    .PAGE_SHIFT (PAGE_SHIFT),
    .GROUP_BITS (GROUP_BITS)
  ) u_map (
    .addr      (cpu_addr),
    .sparse    (map_sparse),
    .hit       (acc_hit),
    .port_addr (mapped_addr)
  );

  iowin_lane_swap #(.NLANES(LANES)) u_wswap (
    .din  (cpu_wdata),
    .size (cpu_size),
    .be   (big_endian),
    .dout (wdata_sw)
  );

  iowin_read_ret u_ret (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_hit   (acc_rd && acc_hit),
    .start_miss  (acc_rd && !acc_hit),
    .req_size    (cpu_size),
    .req_be      (big_endian),
    .port_rvalid (port_rvalid),
    .port_rdata  (port_rdata),
    .pend        (rd_pend),
    .ret_fire    (ret_fire),
    .cpu_rvalid  (cpu_rvalid),
    .cpu_rdata   (cpu_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_addr  <= '0;
      port_rd    <= 1'b0;
      port_wr    <= 1'b0;
      port_size  <= 2'd0;
      port_wdata <= '0;
    end else begin
      port_wr <= acc_wr && acc_hit;
      port_rd <= acc_rd && acc_hit && !rd_pend;
      if ((acc_wr || acc_rd) && acc_hit) begin
        port_addr <= mapped_addr;
        port_size <= cpu_size;
      end
      if (acc_wr && acc_hit) port_wdata <= wdata_sw;
    end
  end
endmodule

// File: rtl/iowin_xlate_chk.sv
`timescale 1ns/1ps
module iowin_xlate_chk #(
  parameter logic [31:0] WIN_BASE = 32'h8000_0000,
  parameter int          WIN_BITS = 23,
  parameter int          PORT_AW  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [31:0]        cpu_addr,
  input logic               cpu_rd,
  input logic               cpu_wr,
  input logic [31:0]        cpu_wdata,
  input logic               map_sparse,
  input logic               big_endian,
  input logic               port_rvalid,
  input logic [PORT_AW-1:0] port_addr,
  input logic               port_rd,
  input logic               port_wr,
  input logic [31:0]        port_wdata,
  input logic               cpu_rvalid,
  input logic               rd_pend,
  input logic               acc_hit
);
  logic in_win;
  assign in_win = cpu_addr[31:WIN_BITS] == WIN_BASE[31:WIN_BITS];

  p_rd_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd |-> $past(cpu_rd && !cpu_wr && in_win));

  p_wr_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |-> $past(cpu_wr && in_win));

  p_dense_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_rd || cpu_wr) && acc_hit && !map_sparse && !rd_pend)
      |=> port_addr == $past(cpu_addr[PORT_AW-1:0]));

  p_le_wdata_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && in_win && !big_endian) |=> port_wdata == $past(cpu_wdata));

  p_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_rd || cpu_wr) && !in_win) |=> !port_rd && !port_wr);

  p_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && port_rvalid) |=> cpu_rvalid && !rd_pend);

  p_stray_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_pend && !(cpu_rd && !cpu_wr)) |=> !cpu_rvalid);

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_rd && port_wr));

  p_reset_quiet_r12: assert property (@(posedge clk)
    !rst_n |=> !port_rd && !port_wr && !cpu_rvalid);
endmodule

bind iowin_xlate iowin_xlate_chk #(
  .WIN_BASE (WIN_BASE),
  .WIN_BITS (WIN_BITS),
  .PORT_AW  (PORT_AW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_addr    (cpu_addr),
  .cpu_rd      (cpu_rd),
  .cpu_wr      (cpu_wr),
  .cpu_wdata   (cpu_wdata),
  .map_sparse  (map_sparse),
  .big_endian  (big_endian),
  .port_rvalid (port_rvalid),
  .port_addr   (port_addr),
  .port_rd     (port_rd),
  .port_wr     (port_wr),
  .port_wdata  (port_wdata),
  .cpu_rvalid  (cpu_rvalid),
  .rd_pend     (rd_pend),
  .acc_hit     (acc_hit)
);

// File: tb/iowin_xlate_test.sv
`timescale 1ns/1ps
module iowin_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [1:0]  cpu_size = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic        map_sparse = 1'b0, big_endian = 1'b0;
  logic [31:0] port_rdata = '0;
  logic        port_rvalid = 1'b0;
  logic [15:0] port_addr;
  logic        port_rd, port_wr;
  logic [1:0]  port_size;
  logic [31:0] port_wdata, cpu_rdata;
  logic        cpu_rvalid;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  iowin_xlate uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .map_sparse(map_sparse), .big_endian(big_endian),
    .port_rdata(port_rdata), .port_rvalid(port_rvalid),
    .port_addr(port_addr), .port_rd(port_rd), .port_wr(port_wr),
    .port_size(port_size), .port_wdata(port_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [1:0]  size;
    logic        sparse;
    logic        be;
    logic [31:0] data;      // write data, or port answer for reads
    logic [15:0] exp_addr;
    logic [31:0] exp_data;  // port_wdata or cpu_rdata
    logic [3:0]  req;       // requirement number for messages
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h8000_1234, 2'd2, 1'b0, 1'b0, 32'hA1B2_C3D4, 16'h1234, 32'hA1B2_C3D4, 4'd2}, // R2 R4
    '{1'b1, 32'h8000_03F8, 2'd0, 1'b0, 1'b1, 32'h0000_0055, 16'h03F8, 32'h0000_0055, 4'd4}, // R4 byte in BE
    '{1'b1, 32'h8000_5678, 2'd1, 1'b0, 1'b1, 32'hCAFE_1122, 16'h5678, 32'hCAFE_2211, 4'd5}, // R5
    '{1'b1, 32'h8000_0010, 2'd2, 1'b0, 1'b1, 32'h1122_3344, 16'h0010, 32'h4433_2211, 4'd6}, // R6
    '{1'b1, 32'h8000_3FF7, 2'd0, 1'b1, 1'b0, 32'h0000_005A, 16'h0077, 32'h0000_005A, 4'd3}, // R3
    '{1'b0, 32'h807F_F01F, 2'd1, 1'b1, 1'b1, 32'h0000_BEEF, 16'hFFFF, 32'h0000_EFBE, 4'd3}, // R3 R5
    '{1'b0, 32'h807F_ABCD, 2'd2, 1'b0, 1'b1, 32'h0102_0304, 16'hABCD, 32'h0403_0201, 4'd6}, // R2 R6
    '{1'b0, 32'h8000_0092, 2'd0, 1'b0, 1'b1, 32'h0000_00EF, 16'h0092, 32'h0000_00EF, 4'd4}, // R4
    '{1'b0, 32'h8012_3456, 2'd2, 1'b1, 1'b0, 32'hDEAD_BEEF, 16'h2476, 32'hDEAD_BEEF, 4'd3}  // R3 R4
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // Drive a one-cycle request; return at the negedge where port strobes show.
  task automatic issue(input logic wr, input logic rd, input logic [31:0] a,
                       input logic [1:0] sz, input logic sp, input logic be,
                       input logic [31:0] wd);
    @(negedge clk);
    cpu_addr = a; cpu_size = sz; map_sparse = sp; big_endian = be;
    cpu_wdata = wd; cpu_wr = wr; cpu_rd = rd;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 port_rd", {31'd0, port_rd}, 32'd0);
    chk("R12 port_wr", {31'd0, port_wr}, 32'd0);
    chk("R12 cpu_rvalid", {31'd0, cpu_rvalid}, 32'd0);
    chk("R12 port_addr", {16'd0, port_addr}, 32'd0);
    rst_n = 1'b1;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].wr, !VECS[i].wr, VECS[i].addr, VECS[i].size,
            VECS[i].sparse, VECS[i].be, VECS[i].data);
      chk($sformatf("R%0d vec%0d strobe", VECS[i].req, i),
          {30'd0, port_wr, port_rd}, VECS[i].wr ? 32'd2 : 32'd1);
      chk($sformatf("R%0d vec%0d addr", VECS[i].req, i), {16'd0, port_addr}, {16'd0, VECS[i].exp_addr});
      chk($sformatf("R11 vec%0d size", i), {30'd0, port_size}, {30'd0, VECS[i].size});
      if (VECS[i].wr) begin
        chk($sformatf("R%0d vec%0d wdata", VECS[i].req, i), port_wdata, VECS[i].exp_data);
      end else begin
        port_rdata = VECS[i].data; port_rvalid = 1'b1;
        @(negedge clk);
        port_rvalid = 1'b0;
        chk($sformatf("R8 vec%0d rvalid", i), {31'd0, cpu_rvalid}, 32'd1);
        chk($sformatf("R%0d vec%0d rdata", VECS[i].req, i), cpu_rdata, VECS[i].exp_data);
      end
      @(negedge clk);
      chk($sformatf("R1 vec%0d pulse", i), {29'd0, port_wr, port_rd, cpu_rvalid}, 32'd0);
    end

    // R1 top edge of window hits, just above misses, just below misses
    issue(1'b1, 1'b0, 32'h807F_FFFF, 2'd0, 1'b0, 1'b0, 32'h1);
    chk("R1 top edge strobe", {31'd0, port_wr}, 32'd1);
    chk("R1 top edge addr", {16'd0, port_addr}, 32'h0000_FFFF);
    issue(1'b1, 1'b0, 32'h8080_0000, 2'd0, 1'b0, 1'b0, 32'h1);
    chk("R1 above window", {30'd0, port_wr, port_rd}, 32'd0);
    issue(1'b1, 1'b0, 32'h7FFF_FFFC, 2'd2, 1'b0, 1'b0, 32'h1);
    chk("R1 below window", {30'd0, port_wr, port_rd}, 32'd0);

    // R7 read outside window
    issue(1'b0, 1'b1, 32'h9000_0000, 2'd2, 1'b0, 1'b1, 32'h0);
    chk("R7 no strobe", {30'd0, port_wr, port_rd}, 32'd0);
    chk("R7 rvalid", {31'd0, cpu_rvalid}, 32'd1);
    chk("R7 rdata", cpu_rdata, 32'd0);

    // R9 / R8: settings change while read pending; answer delayed
    issue(1'b0, 1'b1, 32'h8000_0100, 2'd2, 1'b0, 1'b1, 32'h0);
    chk("R9 strobe", {31'd0, port_rd}, 32'd1);
    big_endian = 1'b0; map_sparse = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 wait no rvalid", {31'd0, cpu_rvalid}, 32'd0);
    end
    port_rdata = 32'hA0B0_C0D0; port_rvalid = 1'b1;
    @(negedge clk);
    port_rvalid = 1'b0;
    chk("R9 rvalid", {31'd0, cpu_rvalid}, 32'd1);
    chk("R9 rdata", cpu_rdata, 32'hD0C0_B0A0);
    // R8 second answer produces nothing
    port_rvalid = 1'b1;
    @(negedge clk);
    port_rvalid = 1'b0;
    chk("R8 once", {31'd0, cpu_rvalid}, 32'd0);

    // R10 stray answer with nothing pending
    @(negedge clk);
    port_rdata = 32'h1234_5678; port_rvalid = 1'b1;
    @(negedge clk);
    port_rvalid = 1'b0;
    chk("R10 stray ignored", {31'd0, cpu_rvalid}, 32'd0);

    // R11 rd and wr together: write only; size code 3 swaps as word (R6)
    issue(1'b1, 1'b1, 32'h8000_0200, 2'd3, 1'b0, 1'b1, 32'h5566_7788);
    chk("R11 dual strobe", {30'd0, port_wr, port_rd}, 32'd2);
    chk("R11 size code", {30'd0, port_size}, 32'd3);
    chk("R6 code3 wdata", port_wdata, 32'h8877_6655);
    port_rvalid = 1'b1;
    @(negedge clk);
    port_rvalid = 1'b0;
    chk("R11 no read return", {31'd0, cpu_rvalid}, 32'd0);

    // R3 page bits [11:5] ignored in sparse map
    issue(1'b1, 1'b0, 32'h8000_3017, 2'd0, 1'b1, 1'b0, 32'h0);
    chk("R3 mid bits ignored", {16'd0, port_addr}, 32'h0000_0077);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule